// File: doc/BRIEF.md
# Width-Adapting Static Memory Interface

This block sits between a 32-bit on-chip request port and external asynchronous static memory. Each request is a byte, halfword or word. The block works out which of the four byte lanes the request occupies from its size and its two low address bits. It then drives chip-enable, output-enable or write-enable, an address, active-low byte strobes and a data bus with separate drive enables for the lower and upper halves. Read data returns in the lane position of the request, and all unused lanes are forced to zero.

One inclusive address window, given by a base and a limit, marks memory that is only 16 bits wide. Every other address is treated as full 32-bit memory. In the narrow window, only external data bits 15:0 are used, and the drive enable for the upper half never rises. A word request there is carried out as two halfword cycles: the lower halfword at the word address, then the upper halfword at the next halfword address. Chip-enable stays low across both halves. The requester sees a single merged response with no software help. A wait-state count stretches every strobe pulse.

The requester raises `reqValid` for one cycle while the block is idle. The block then latches the request and later pulses `reqReady` for one cycle. On a read, `rspRdata` holds the result during that pulse. A `reqValid` that arrives while a request is in progress is ignored.

Top module: `width_adapt_smem`

## Requirements
- R1: While reset is held and right after it is released, `memCeN`, `memOeN` and `memWeN` are 1, both drive enables are 0, `reqReady` is 0 and `rspRdata` is 0.
- R2: A read outside the narrow window returns the external word masked to the request's lanes, with every other lane at zero. The lanes are: a byte (size 0) uses lane addr[1:0], where lane n is bits 8n+7:8n; a halfword (size 1) uses bits 31:16 when addr[1]=1 and bits 15:0 otherwise; a word (size 2 or 3) uses all lanes.
- R3: A write outside the narrow window drives `memBeN` low only for the request's lanes (bit n covers lane n), so bytes in other lanes of the external word are left unchanged.
- R4: An address is in the narrow window when cfgNarrowBase <= addr <= cfgNarrowLimit, with both bounds inclusive. An address one above the limit is treated as 32-bit memory.
- R5: A word read in the narrow window makes two read strobe pulses, the first at address {addr[high:2],00} and the second at {addr[high:2],10}. The response is {second halfword, first halfword}, each halfword taken from external bits 15:0.
- R6: A byte or halfword access in the narrow window makes exactly one strobe pulse at address {addr[high:1],0}. A halfword read returns external bits 15:0 in the halfword lane selected by addr[1]. A byte read takes external bits 15:8 when addr[0]=1 and bits 7:0 otherwise, and places them in lane addr[1:0]. A byte write strobes only `memBeN[addr[0]]`. `memDoutEnHi` never rises for a narrow address.
- R7: Between the two halves of a split access, `memCeN` stays low and the active strobe is high for at least one clock. `memCeN` rises once per request.
- R8: With wait count w, each strobe pulse lasts w+1 clocks. `reqReady` is seen w+1 clocks after the accepting edge for a single-cycle access and 2w+3 clocks after it for a split access.
- R9: `reqReady` is a single-cycle pulse per request, and a `reqValid` that arrives while a request is in progress starts no access.
- R10: A word write in the narrow window sends data bits 15:0 in the first pulse and bits 31:16 in the second, with `memBeN[1:0]`=00 in both pulses.
- R11: `memOeN` and `memWeN` are never low together, and a drive enable is high only while `memWeN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, sampled while idle |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqWdata | input | 32 | Write data in lane position |
| reqReady | output | 1 | One-cycle completion pulse |
| rspRdata | output | 32 | Read result in lane position, unused lanes zero |
| cfgNarrowBase | input | ADDR_W | Lowest address of the 16-bit window |
| cfgNarrowLimit | input | ADDR_W | Highest address of the 16-bit window |
| cfgWaitStates | input | WAIT_W | Extra clocks per strobe pulse |
| memCeN | output | 1 | External chip-enable, active low |
| memOeN | output | 1 | External output-enable, active low |
| memWeN | output | 1 | External write-enable, active low |
| memAddr | output | ADDR_W | External byte address of the current cycle |
| memBeN | output | 4 | Active-low byte strobes |
| memDout | output | 32 | Data driven toward memory |
| memDoutEnLo | output | 1 | Drive enable for data bits 15:0 |
| memDoutEnHi | output | 1 | Drive enable for data bits 31:16 |
| memDin | input | 32 | Data received from memory |

## Verification
The bench builds the block with ADDR_W=12 and WAIT_W=4. It sets the narrow window to 0x100..0x1FF, so the window's lower edge, its upper edge and the first 32-bit address beyond it all fall inside a small memory model. The bench model drives 0xFFFF on the upper half of the data bus for narrow addresses, so any leak of those bits into a result is visible. Runs with wait counts of 0, 3 and 15 cover the shortest access, a busy window long enough to inject a stray request, and the widest value the 4-bit count can hold.

// File: rtl/wsi_pkg.sv
package wsi_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRES = 2'd3
  } xferSize_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;
    logic ceActive;
    logic rdStrobe;
    logic wrStrobe;
    logic secondHalf;
    logic capture;
  } ctrlStrobes_t;
endpackage

// File: rtl/wsi_ctrl.sv
module wsi_ctrl
  import wsi_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              isSplit,
  input  logic              isWrite,
  output ctrlStrobes_t      ctl,
  output logic              reqReady
);
  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_GAP, ST_DONE} seqState_e;

  seqState_e         state;
  logic [WAIT_W-1:0] waitCnt;
  logic              second;
  logic              lastClock;

  assign lastClock = (waitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      second  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqValid) begin
          state   <= ST_ACCESS;
          waitCnt <= cfgWait;
          second  <= 1'b0;
        end
        ST_ACCESS: begin
          if (lastClock) state <= (isSplit && !second) ? ST_GAP : ST_DONE;
          else           waitCnt <= waitCnt - 1'b1;
        end
        ST_GAP: begin
          state   <= ST_ACCESS;
          waitCnt <= cfgWait;
          second  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load       = (state == ST_IDLE) && reqValid;
    ctl.ceActive   = (state == ST_ACCESS) || (state == ST_GAP);
    ctl.rdStrobe   = (state == ST_ACCESS) && !isWrite;
    ctl.wrStrobe   = (state == ST_ACCESS) && isWrite;
    ctl.secondHalf = second;
    ctl.capture    = (state == ST_ACCESS) && lastClock;
  end

  assign reqReady = (state == ST_DONE);
endmodule

// File: rtl/wsi_datapath.sv
module wsi_datapath
  import wsi_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctl,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic [ADDR_W-1:0] cfgNarrowBase,
  input  logic [ADDR_W-1:0] cfgNarrowLimit,
  input  logic [31:0]       memDin,
  output logic              isSplit,
  output logic              isWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memBeN,
  output logic [31:0]       memDout,
  output logic              memDoutEnLo,
  output logic              memDoutEnHi,
  output logic [31:0]       rspRdata
);
  localparam int LANES = 4;

  logic              rWrite;
  xferSize_e         rSize;
  logic [ADDR_W-1:0] rAddr;
  logic [31:0]       rWdata;
  logic              rNarrow;
  logic [15:0]       lowHalf;
  logic [LANES-1:0]  laneMask;
  logic [31:0]       laneBits;
  logic [1:0]        narrowMask;
  logic [15:0]       wrHalf;
  logic [15:0]       rdHalf;
  logic [7:0]        rdByte;
  logic [31:0]       rdResult;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rWrite  <= 1'b0;
      rSize   <= SZ_BYTE;
      rAddr   <= '0;
      rWdata  <= '0;
      rNarrow <= 1'b0;
    end else if (ctl.load) begin
      rWrite  <= reqWrite;
      rSize   <= xferSize_e'(reqSize);
      rAddr   <= reqAddr;
      rWdata  <= reqWdata;
      rNarrow <= (reqAddr >= cfgNarrowBase) && (reqAddr <= cfgNarrowLimit);
    end
  end

  assign isWrite = rWrite;
  assign isSplit = rNarrow && (rSize == SZ_WORD || rSize == SZ_WRES);

  always_comb begin
    unique case (rSize)
      SZ_BYTE: laneMask = 4'b0001 << rAddr[1:0];
      SZ_HALF: laneMask = rAddr[1] ? 4'b1100 : 4'b0011;
      default: laneMask = 4'b1111;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneBits[8*i +: 8] = {8{laneMask[i]}};
  end

  // narrow side: one halfword per external cycle on bits 15:0
  assign narrowMask = (rSize == SZ_BYTE) ? (rAddr[0] ? 2'b10 : 2'b01) : 2'b11;
  assign wrHalf = (isSplit ? ctl.secondHalf : rAddr[1]) ? rWdata[31:16] : rWdata[15:0];

  always_comb begin
    if (rNarrow) begin
      memAddr = isSplit ? {rAddr[ADDR_W-1:2], ctl.secondHalf, 1'b0}
                        : {rAddr[ADDR_W-1:1], 1'b0};
      memBeN  = {2'b11, ~narrowMask};
      memDout = {16'h0000, wrHalf & {{8{narrowMask[1]}}, {8{narrowMask[0]}}}};
    end else begin
      memAddr = {rAddr[ADDR_W-1:2], 2'b00};
      memBeN  = ~laneMask;
      memDout = rWdata & laneBits;
    end
  end

  assign memDoutEnLo = ctl.wrStrobe;
  assign memDoutEnHi = ctl.wrStrobe && !rNarrow;

  assign rdHalf = memDin[15:0];
  assign rdByte = rAddr[0] ? memDin[15:8] : memDin[7:0];

  always_comb begin
    if (rWrite)                 rdResult = '0;
    else if (!rNarrow)          rdResult = memDin & laneBits;
    else if (isSplit)           rdResult = {rdHalf, lowHalf};
    else if (rSize == SZ_HALF)  rdResult = rAddr[1] ? {rdHalf, 16'h0000} : {16'h0000, rdHalf};
    else                        rdResult = {24'h000000, rdByte} << {rAddr[1:0], 3'b000};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowHalf  <= '0;
      rspRdata <= '0;
    end else if (ctl.capture) begin
      if (isSplit && !ctl.secondHalf) lowHalf  <= rdHalf;
      else                            rspRdata <= rdResult;
    end
  end
endmodule

// File: rtl/width_adapt_smem.sv
module width_adapt_smem
  import wsi_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              reqReady,
  output logic [31:0]       rspRdata,
  input  logic [ADDR_W-1:0] cfgNarrowBase,
  input  logic [ADDR_W-1:0] cfgNarrowLimit,
  input  logic [WAIT_W-1:0] cfgWaitStates,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memBeN,
  output logic [31:0]       memDout,
  output logic              memDoutEnLo,
  output logic              memDoutEnHi,
  input  logic [31:0]       memDin
);
  ctrlStrobes_t ctl;
  logic         isSplit;
  logic         isWrite;

  wsi_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cfgWait  (cfgWaitStates),
    .isSplit  (isSplit),
    .isWrite  (isWrite),
    .ctl      (ctl),
    .reqReady (reqReady)
  );

  wsi_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .ctl            (ctl),
    .reqWrite       (reqWrite),
    .reqSize        (reqSize),
    .reqAddr        (reqAddr),
    .reqWdata       (reqWdata),
    .cfgNarrowBase  (cfgNarrowBase),
    .cfgNarrowLimit (cfgNarrowLimit),
    .memDin         (memDin),
    .isSplit        (isSplit),
    .isWrite        (isWrite),
    .memAddr        (memAddr),
    .memBeN         (memBeN),
    .memDout        (memDout),
    .memDoutEnLo    (memDoutEnLo),
    .memDoutEnHi    (memDoutEnHi),
    .rspRdata       (rspRdata)
  );

  assign memCeN = ~ctl.ceActive;
  assign memOeN = ~ctl.rdStrobe;
  assign memWeN = ~ctl.wrStrobe;
endmodule

// File: rtl/width_adapt_smem_chk.sv
module width_adapt_smem_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memDoutEnLo,
  input logic              memDoutEnHi
);
  // R11
  no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  // R11
  drive_only_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memDoutEnLo || memDoutEnHi) |-> (memOeN && !memWeN && !memCeN));

  // R7
  strobe_inside_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN || !memWeN) |-> !memCeN);

  // R7
  addr_steady_in_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN && $past(!memOeN)) |-> $stable(memAddr));

  // R7
  addr_steady_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> $stable(memAddr));

  // R9
  single_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady);

  // R9
  ready_after_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && $past(!memCeN)));

  // R6
  hi_needs_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDoutEnHi |-> memDoutEnLo);
endmodule

bind width_adapt_smem width_adapt_smem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqReady    (reqReady),
  .memCeN      (memCeN),
  .memOeN      (memOeN),
  .memWeN      (memWeN),
  .memAddr     (memAddr),
  .memDoutEnLo (memDoutEnLo),
  .memDoutEnHi (memDoutEnHi)
);

// File: tb/tb_width_adapt_smem.sv
module tb_width_adapt_smem;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]    reqSize = 2'd0;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0]   reqWdata = '0;
  logic          reqReady;
  logic [31:0]   rspRdata;
  logic [WW-1:0] cfgWait = '0;
  logic          memCeN, memOeN, memWeN, memDoutEnLo, memDoutEnHi;
  logic [AW-1:0] memAddr;
  logic [3:0]    memBeN;
  logic [31:0]   memDout, memDin;

  always #(CLK_PERIOD/2) clk = ~clk;

  width_adapt_smem #(.ADDR_W(AW), .WAIT_W(WW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .rspRdata(rspRdata),
    .cfgNarrowBase(12'h100), .cfgNarrowLimit(12'h1FF), .cfgWaitStates(cfgWait),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN), .memAddr(memAddr),
    .memBeN(memBeN), .memDout(memDout), .memDoutEnLo(memDoutEnLo),
    .memDoutEnHi(memDoutEnHi), .memDin(memDin)
  );

  int checks = 0, failures = 0;
  logic [31:0] wideMem [64];
  logic [15:0] narrowMem [128];

  function automatic bit inN(input logic [AW-1:0] a);
    return (a >= 12'h100) && (a <= 12'h1FF);
  endfunction

  // external memory model; narrow region pulls the upper half high
  always_comb begin
    if (inN(memAddr)) memDin = {16'hFFFF, narrowMem[memAddr[7:1]]};
    else              memDin = wideMem[memAddr[7:2]];
  end

  always @(posedge clk) begin
    if (!memWeN && !memCeN) begin
      if (inN(memAddr)) begin
        for (int i = 0; i < 2; i++)
          if (!memBeN[i]) narrowMem[memAddr[7:1]][8*i +: 8] = memDout[8*i +: 8];
      end else begin
        for (int i = 0; i < 4; i++)
          if (!memBeN[i]) wideMem[memAddr[7:2]][8*i +: 8] = memDout[8*i +: 8];
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] laneBitsOf(input logic [1:0] sz, input logic [AW-1:0] a);
    logic [3:0] m;
    logic [31:0] b;
    if (sz == 2'd0)      m = 4'b0001 << a[1:0];
    else if (sz == 2'd1) m = a[1] ? 4'b1100 : 4'b0011;
    else                 m = 4'b1111;
    for (int i = 0; i < 4; i++) b[8*i +: 8] = {8{m[i]}};
    return b;
  endfunction

  function automatic logic [31:0] expRead(input logic [1:0] sz, input logic [AW-1:0] a);
    logic [15:0] h;
    logic [7:0]  b;
    if (!inN(a)) return wideMem[a[7:2]] & laneBitsOf(sz, a);
    if (sz >= 2'd2) return {narrowMem[{a[7:2], 1'b1}], narrowMem[{a[7:2], 1'b0}]};
    h = narrowMem[a[7:1]];
    if (sz == 2'd1) return a[1] ? {h, 16'h0000} : {16'h0000, h};
    b = a[0] ? h[15:8] : h[7:0];
    return {24'h0, b} << {a[1:0], 3'b000};
  endfunction

  // scoreboard
  bit          expIsRd [$];
  logic [31:0] expVal  [$];
  string       expTag  [$];
  logic        prevReady = 1'b0;

  always @(negedge clk) begin
    if (reqReady) begin
      if (prevReady) check("R9 ready pulse width", 32'd2, 32'd1);
      if (expVal.size() == 0) check("R9 unexpected ready", 32'd1, 32'd0);
      else begin
        if (expIsRd[0]) check(expTag[0], rspRdata, expVal[0]);
        void'(expIsRd.pop_front()); void'(expVal.pop_front()); void'(expTag.pop_front());
      end
    end
    prevReady = reqReady;
  end

  // strobe recorder
  logic [AW-1:0] pulseAddr [$];
  int            pulseLen  [$];
  logic [3:0]    pulseBe   [$];
  logic [31:0]   pulseDout [$];
  int            ceRises = 0, hiViol = 0;
  logic          prevStrobe = 1'b0, prevCe = 1'b1;

  always @(negedge clk) begin
    logic s;
    s = !memOeN || !memWeN;
    if (s && !prevStrobe) begin
      pulseAddr.push_back(memAddr); pulseLen.push_back(1);
      pulseBe.push_back(memBeN); pulseDout.push_back(memDout);
    end else if (s) pulseLen[pulseLen.size()-1]++;
    if (memCeN && !prevCe) ceRises++;
    if (memDoutEnHi && inN(memAddr)) hiViol++;
    prevStrobe = s;
    prevCe = memCeN;
  end

  task automatic doReq(input string tag, input bit wr, input logic [1:0] sz,
                       input logic [AW-1:0] a, input logic [31:0] wd,
                       input bit poke, output int lat);
    pulseAddr.delete(); pulseLen.delete(); pulseBe.delete(); pulseDout.delete();
    ceRises = 0;
    expIsRd.push_back(!wr);
    expVal.push_back(wr ? 32'h0 : expRead(sz, a));
    expTag.push_back(tag);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqAddr = a; reqWdata = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0;
    while (!reqReady) begin
      lat++;
      if (poke && lat == 1) begin reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 12'h000; end
      if (poke && lat == 2) reqValid = 1'b0;
      @(negedge clk);
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat;
    logic [31:0] old;
    logic [15:0] oldH;
    for (int i = 0; i < 64; i++) wideMem[i] = (i * 32'h01030507) ^ 32'hC3A50F96;
    for (int i = 0; i < 128; i++) narrowMem[i] = 16'h5000 + i * 16'h0103;

    repeat (3) @(negedge clk);
    check("R1 reset strobes", {29'h0, memCeN, memOeN, memWeN}, 32'h7);
    check("R1 reset enables/ready", {29'h0, memDoutEnLo, memDoutEnHi, reqReady}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release strobes", {29'h0, memCeN, memOeN, memWeN}, 32'h7);
    check("R1 after release rdata", rspRdata, 32'h0);

    // wide reads, no wait
    doReq("R2 wide word read", 0, 2'd2, 12'h010, 0, 0, lat);
    check("R8 wide latency w0", lat, 1);
    check("R8 pulse length w0", pulseLen[0], 1);
    doReq("R2 wide upper half read", 0, 2'd1, 12'h012, 0, 0, lat);
    doReq("R2 wide lower half read", 0, 2'd1, 12'h014, 0, 0, lat);
    doReq("R2 wide byte3 read", 0, 2'd0, 12'h013, 0, 0, lat);
    doReq("R2 wide byte1 read", 0, 2'd0, 12'h031, 0, 0, lat);

    // narrow word read
    doReq("R5 narrow word read", 0, 2'd2, 12'h120, 0, 0, lat);
    check("R5 pulse count", pulseAddr.size(), 2);
    check("R5 first addr", pulseAddr[0], 12'h120);
    check("R5 second addr", pulseAddr[1], 12'h122);
    check("R8 split latency w0", lat, 3);
    check("R7 single ce rise", ceRises, 1);

    // narrow byte / half
    doReq("R6 narrow upper half read", 0, 2'd1, 12'h126, 0, 0, lat);
    check("R6 half one pulse", pulseAddr.size(), 1);
    check("R6 half addr", pulseAddr[0], 12'h126);
    doReq("R6 narrow lower half read", 0, 2'd1, 12'h130, 0, 0, lat);
    doReq("R6 narrow byte3 read", 0, 2'd0, 12'h127, 0, 0, lat);
    check("R6 byte addr", pulseAddr[0], 12'h126);
    doReq("R6 narrow byte1 read", 0, 2'd0, 12'h135, 0, 0, lat);
    doReq("R6 narrow byte0 read", 0, 2'd0, 12'h138, 0, 0, lat);

    // window bounds
    doReq("R4 base word read", 0, 2'd2, 12'h100, 0, 0, lat);
    check("R4 base is narrow", pulseAddr.size(), 2);
    doReq("R4 top word read", 0, 2'd2, 12'h1FC, 0, 0, lat);
    check("R4 top is narrow", pulseAddr.size(), 2);
    doReq("R4 above limit read", 0, 2'd2, 12'h200, 0, 0, lat);
    check("R4 above limit is wide", pulseAddr.size(), 1);
    doReq("R4 below base read", 0, 2'd2, 12'h0FC, 0, 0, lat);
    check("R4 below base is wide", pulseAddr.size(), 1);

    // wait states
    cfgWait = 4'd3;
    doReq("R8 wide read w3", 0, 2'd2, 12'h040, 0, 0, lat);
    check("R8 wide latency w3", lat, 4);
    check("R8 pulse length w3", pulseLen[0], 4);
    doReq("R9 narrow read with stray request", 0, 2'd2, 12'h150, 0, 1, lat);
    check("R8 split latency w3", lat, 9);
    check("R8 second pulse length w3", pulseLen[1], 4);
    check("R9 stray request ignored", pulseAddr.size(), 2);
    check("R7 ce held across halves w3", ceRises, 1);
    cfgWait = 4'd15;
    doReq("R8 narrow read w15", 0, 2'd2, 12'h160, 0, 0, lat);
    check("R8 split latency w15", lat, 33);

    // writes
    cfgWait = 4'd1;
    old = wideMem[8];
    doReq("R3 wide byte write", 1, 2'd0, 12'h021, 32'hAABBCCDD, 0, lat);
    check("R3 wide byte write strobes", {28'h0, pulseBe[0]}, 32'hD);
    check("R3 wide byte write mem", wideMem[8], {old[31:16], 8'hCC, old[7:0]});
    old = wideMem[8];
    doReq("R3 wide half write", 1, 2'd1, 12'h022, 32'h1122EEFF, 0, lat);
    check("R3 wide half write mem", wideMem[8], {16'h1122, old[15:0]});
    doReq("R2 wide readback", 0, 2'd2, 12'h020, 0, 0, lat);

    doReq("R10 narrow word write", 1, 2'd2, 12'h140, 32'h12345678, 0, lat);
    check("R10 first addr", pulseAddr[0], 12'h140);
    check("R10 first data", pulseDout[0], 32'h00005678);
    check("R10 second data", pulseDout[1], 32'h00001234);
    check("R10 strobes", {24'h0, pulseBe[0], pulseBe[1]}, 32'hCC);
    check("R10 mem low", narrowMem[8'h20 >> 0], 16'h5678);
    check("R10 mem high", narrowMem[8'h21], 16'h1234);
    check("R7 write split ce", ceRises, 1);
    oldH = narrowMem[8'h21];
    doReq("R6 narrow byte write", 1, 2'd0, 12'h143, 32'h11223344, 0, lat);
    check("R6 byte write strobes", {28'h0, pulseBe[0]}, 32'hD);
    check("R6 byte write mem", narrowMem[8'h21], {8'h11, oldH[7:0]});
    check("R6 upper drive never on narrow", hiViol, 0);
    doReq("R5 narrow readback", 0, 2'd2, 12'h140, 0, 0, lat);

    repeat (2) @(negedge clk);
    check("R9 scoreboard drained", expVal.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule